// File: doc/BRIEF.md
# Instrumentation Trace Packet Parser

This block turns the byte stream of a software/hardware instrumentation trace source into typed packets. Every byte arriving with `byteValid` is either the header of a new packet or a payload byte of the packet in progress. The header alone fixes the packet class and how many bytes follow. When the last byte of a packet arrives, the parser raises `pktValid` for one cycle. At the same moment it presents the class, the source channel, the assembled payload, the timestamp control code, the running timestamp total and the exception fields.

Local timestamps come in two forms. The short form fits in the header byte. The long form is continuation-coded over up to four further bytes. Each decoded value is added to a running total. Exception-trace packets are split into a 9-bit exception number and a 4-bit event code. A run of zero bytes closed by 0x80 is recognised as the alignment pattern in any state. Upstream logic can assert `gapTimeout` after a long silence on the link, and this drops any half-received packet.

Top module: `instr_trace_parser`

## Requirements
- R1: After reset `pktValid` is 0 and `tsAccum` is 0.
- R2: `SYNC_ZEROS` (default 5) or more consecutive 0x00 bytes followed by 0x80 produce one packet of type 0 (sync), with payload 0 and `srcId` 0, in any parser state. A header byte whose low 7 bits are zero produces no packet, so 0x80 after fewer zeros is ignored.
- R3: Header 0x70 produces a one-byte packet of type 1 (overflow) with payload 0. It takes priority over the timestamp class.
- R4: A header whose bits 1:0 are nonzero is a source packet. Bit 2 = 0 gives type 6 (software) and bit 2 = 1 gives type 7 (hardware). Size code 1, 2 or 3 in bits 1:0 means 1, 2 or 4 payload bytes. `srcId` is header bits 7:3. The payload is little-endian: the first byte goes to bits 7:0 and unused upper bytes are zero.
- R5: A header with low nibble 0, a nonzero upper nibble and bit 7 clear is a one-byte timestamp of type 2. Its value is header bits 6:4 and `tsCtrl` is 0.
- R6: A timestamp header with bit 7 set takes `tsCtrl` from header bits 5:4. Following bytes each contribute 7 bits, least significant group first. The packet ends at a byte with bit 7 clear, or at the fourth byte regardless. The value appears in `payload`.
- R7: Each timestamp value is added to `tsAccum` (modulo 2^`TS_W`). The updated total is visible in the cycle `pktValid` is high, and no other packet changes it.
- R8: Low nibble 0x8, 0xC and 0x4 give one-byte packets of type 3 (software extension), 4 (hardware extension) and 5 (reserved), each with payload 0.
- R9: For a hardware packet with `srcId` 1, `excNum` is {payload byte 1 bit 0, payload byte 0} and `excEvent` is payload byte 1 bits 7:4. For every other packet both fields are 0.
- R10: `gapTimeout` drops any partial packet. A byte arriving in the same cycle as the timeout is taken as a new header.
- R11: `pktValid` is high for exactly one cycle, in the cycle after the clock edge that takes in the packet's last byte. It is never high without a byte taken in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A trace byte is present this cycle |
| byteData | input | 8 | Trace byte |
| gapTimeout | input | 1 | Link silence detected upstream; drop partial packet |
| pktValid | output | 1 | One-cycle strobe: a packet is complete |
| pktType | output | 3 | Packet class, encoded as listed in R2 to R8 |
| srcId | output | 5 | Source channel of a source packet, else 0 |
| payload | output | 32 | Little-endian payload or timestamp value |
| tsCtrl | output | 2 | Timestamp control code (exact / ts delayed / event delayed / both) |
| tsAccum | output | TS_W | Running sum of timestamp values |
| excNum | output | 9 | Exception number of an exception-trace packet |
| excEvent | output | 4 | Exception event: 1 enter, 2 exit, 3 resume |

## Verification
Seeded random source packets cover all three sizes and both source kinds with random channels. This separates errors in the length decoding from errors in byte lane placement, and the random channels make exception-trace packets on channel 1 appear among the others. Random long timestamps vary the continuation length and the control code. Some of them set bit 7 on a fourth byte, which shows whether the forced end at four bytes is honoured, and every one of them also checks the running total. Directed sequences cover the alignment pattern with too few, exactly enough and extra zeros, the one-byte classes, and a timeout both alone and together with a new header byte.

// File: rtl/instr_trace_pkg.sv
package instr_trace_pkg;

  typedef enum logic [2:0] {
    PK_SYNC     = 3'd0,
    PK_OVERFLOW = 3'd1,
    PK_TSTAMP   = 3'd2,
    PK_SWEXT    = 3'd3,
    PK_HWEXT    = 3'd4,
    PK_RESERVED = 3'd5,
    PK_SOFT     = 3'd6,
    PK_HARD     = 3'd7
  } pkt_kind_e;

  // control to datapath strobes
  typedef struct packed {
    logic      loadHdr;
    logic      loadData;
    logic      emit;
    logic [2:0] idx;
    pkt_kind_e kind;
  } ctl_strobe_t;

  // header classification; PK_SYNC here means "alignment byte, no packet"
  function automatic pkt_kind_e classifyHdr(input logic [7:0] b);
    pkt_kind_e k;
    if (b[6:0] == 7'd0)      k = PK_SYNC;
    else if (b == 8'h70)     k = PK_OVERFLOW;
    else begin
      case (b[3:0])
        4'h0:    k = PK_TSTAMP;
        4'h8:    k = PK_SWEXT;
        4'hC:    k = PK_HWEXT;
        4'h4:    k = PK_RESERVED;
        default: k = b[2] ? PK_HARD : PK_SOFT;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/instr_trace_ctrl.sv
module instr_trace_ctrl
  import instr_trace_pkg::*;
#(
  parameter int SYNC_ZEROS   = 5,
  parameter int TS_MAX_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteIn,
  input  logic        gapTimeout,
  output ctl_strobe_t strb
);

  localparam int ZC_W  = $clog2(SYNC_ZEROS + 1);
  localparam int IDX_W = 3;

  logic             inPkt, inPktN;
  pkt_kind_e        curKind, curKindN;
  logic [IDX_W-1:0] idx, idxN;
  logic [IDX_W-1:0] lastIdx, lastIdxN;
  logic [ZC_W-1:0]  zeroCnt, zeroCntN;
  logic             syncHit;
  logic             done;
  pkt_kind_e        hk;

  assign syncHit = byteValid && (byteIn == 8'h80) && (zeroCnt == ZC_W'(SYNC_ZEROS));

  always_comb begin
    zeroCntN = zeroCnt;
    if (byteValid) begin
      if (byteIn != 8'h00)                    zeroCntN = '0;
      else if (zeroCnt != ZC_W'(SYNC_ZEROS))  zeroCntN = zeroCnt + 1'b1;
    end
  end

  always_comb begin
    strb     = '0;
    inPktN   = inPkt;
    curKindN = curKind;
    idxN     = idx;
    lastIdxN = lastIdx;
    hk       = classifyHdr(byteIn);
    done     = 1'b0;
    if (byteValid) begin
      if (syncHit) begin
        strb.emit = 1'b1;
        strb.kind = PK_SYNC;
        inPktN    = 1'b0;
      end else if (!inPkt || gapTimeout) begin
        strb.kind = hk;
        idxN      = '0;
        curKindN  = hk;
        case (hk)
          PK_SYNC: inPktN = 1'b0;
          PK_TSTAMP: begin
            strb.loadHdr = 1'b1;
            if (!byteIn[7]) begin
              strb.emit = 1'b1;
              inPktN    = 1'b0;
            end else begin
              inPktN   = 1'b1;
              lastIdxN = IDX_W'(TS_MAX_BYTES - 1);
            end
          end
          PK_SOFT, PK_HARD: begin
            strb.loadHdr = 1'b1;
            inPktN       = 1'b1;
            case (byteIn[1:0])
              2'd1:    lastIdxN = IDX_W'(0);
              2'd2:    lastIdxN = IDX_W'(1);
              2'd3:    lastIdxN = IDX_W'(3);
              default: begin
                strb.emit = 1'b1;
                inPktN    = 1'b0;
              end
            endcase
          end
          default: begin
            strb.loadHdr = 1'b1;
            strb.emit    = 1'b1;
            inPktN       = 1'b0;
          end
        endcase
      end else begin
        strb.loadData = 1'b1;
        strb.idx      = idx;
        strb.kind     = curKind;
        done = ((curKind == PK_TSTAMP) && !byteIn[7]) || (idx == lastIdx);
        if (done) begin
          strb.emit = 1'b1;
          inPktN    = 1'b0;
        end else begin
          idxN = idx + 1'b1;
        end
      end
    end else if (gapTimeout) begin
      inPktN = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt   <= 1'b0;
      curKind <= PK_SYNC;
      idx     <= '0;
      lastIdx <= '0;
      zeroCnt <= '0;
    end else begin
      inPkt   <= inPktN;
      curKind <= curKindN;
      idx     <= idxN;
      lastIdx <= lastIdxN;
      zeroCnt <= zeroCntN;
    end
  end

endmodule

// File: rtl/instr_trace_dp.sv
module instr_trace_dp
  import instr_trace_pkg::*;
#(
  parameter int TS_W         = 32,
  parameter int TS_MAX_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      byteIn,
  input  ctl_strobe_t     strb,
  output logic            pktValid,
  output logic [2:0]      pktType,
  output logic [4:0]      srcId,
  output logic [31:0]     payload,
  output logic [1:0]      tsCtrl,
  output logic [TS_W-1:0] tsAccum,
  output logic [8:0]      excNum,
  output logic [3:0]      excEvent
);

  localparam int PAY_BYTES = 4;
  localparam int PAY_W     = 8 * PAY_BYTES;
  localparam int TSV_W     = 7 * TS_MAX_BYTES;

  logic [7:3]       hdrReg, hdrNow;
  logic [PAY_W-1:0] asmReg, asmNext;
  logic [TSV_W-1:0] tsReg, tsNext;
  logic [PAY_BYTES-1:0]    laneSel;
  logic [TS_MAX_BYTES-1:0] groupSel;
  logic isSrc, isTs;

  genvar g;
  generate
    for (g = 0; g < PAY_BYTES; g++) begin : g_lane
      assign laneSel[g] = strb.loadData && (strb.idx == 3'(g));
    end
    for (g = 0; g < TS_MAX_BYTES; g++) begin : g_group
      assign groupSel[g] = strb.loadData && (strb.idx == 3'(g));
    end
  endgenerate

  always_comb begin
    hdrNow  = strb.loadHdr ? byteIn[7:3] : hdrReg;
    asmNext = strb.loadHdr ? '0 : asmReg;
    tsNext  = strb.loadHdr ? (byteIn[7] ? '0 : TSV_W'(byteIn[6:4])) : tsReg;
    for (int l = 0; l < PAY_BYTES; l++)
      if (laneSel[l]) asmNext[l*8 +: 8] = byteIn;
    for (int l = 0; l < TS_MAX_BYTES; l++)
      if (groupSel[l]) tsNext[l*7 +: 7] = byteIn[6:0];
  end

  assign isSrc = (strb.kind == PK_SOFT) || (strb.kind == PK_HARD);
  assign isTs  = (strb.kind == PK_TSTAMP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrReg   <= '0;
      asmReg   <= '0;
      tsReg    <= '0;
      pktValid <= 1'b0;
      pktType  <= 3'd0;
      srcId    <= '0;
      payload  <= '0;
      tsCtrl   <= '0;
      tsAccum  <= '0;
      excNum   <= '0;
      excEvent <= '0;
    end else begin
      hdrReg   <= hdrNow;
      asmReg   <= asmNext;
      tsReg    <= tsNext;
      pktValid <= strb.emit;
      if (strb.emit) begin
        pktType <= strb.kind;
        srcId   <= isSrc ? hdrNow : '0;
        payload <= isTs ? PAY_W'(tsNext) : (isSrc ? asmNext : '0);
        tsCtrl  <= (isTs && hdrNow[7]) ? hdrNow[5:4] : 2'd0;
        if (isTs) tsAccum <= tsAccum + TS_W'(tsNext);
        if ((strb.kind == PK_HARD) && (hdrNow == 5'd1)) begin
          excNum   <= {asmNext[8], asmNext[7:0]};
          excEvent <= asmNext[15:12];
        end else begin
          excNum   <= '0;
          excEvent <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/instr_trace_parser.sv
module instr_trace_parser
  import instr_trace_pkg::*;
#(
  parameter int TS_W         = 32,
  parameter int SYNC_ZEROS   = 5,
  parameter int TS_MAX_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            byteValid,
  input  logic [7:0]      byteData,
  input  logic            gapTimeout,
  output logic            pktValid,
  output logic [2:0]      pktType,
  output logic [4:0]      srcId,
  output logic [31:0]     payload,
  output logic [1:0]      tsCtrl,
  output logic [TS_W-1:0] tsAccum,
  output logic [8:0]      excNum,
  output logic [3:0]      excEvent
);

  ctl_strobe_t strb;

  instr_trace_ctrl #(.SYNC_ZEROS(SYNC_ZEROS), .TS_MAX_BYTES(TS_MAX_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteData),
    .gapTimeout(gapTimeout), .strb(strb)
  );

  instr_trace_dp #(.TS_W(TS_W), .TS_MAX_BYTES(TS_MAX_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .byteIn(byteData), .strb(strb),
    .pktValid(pktValid), .pktType(pktType), .srcId(srcId), .payload(payload),
    .tsCtrl(tsCtrl), .tsAccum(tsAccum), .excNum(excNum), .excEvent(excEvent)
  );

endmodule

// File: rtl/instr_trace_chk.sv
module instr_trace_chk #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            byteValid,
  input logic            gapTimeout,
  input logic            pktValid,
  input logic [2:0]      pktType,
  input logic [4:0]      srcId,
  input logic [31:0]     payload,
  input logic [1:0]      tsCtrl,
  input logic [TS_W-1:0] tsAccum,
  input logic [8:0]      excNum,
  input logic [3:0]      excEvent
);

  // R11
  strobe_follows_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> !pktValid);

  // R10
  timeout_no_packet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gapTimeout && !byteValid) |=> !pktValid);

  // R7
  accum_only_on_ts_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pktValid && pktType == 3'd2) |-> $stable(tsAccum));

  // R9
  exc_zero_else_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktType != 3'd7) |-> (excNum == 9'd0 && excEvent == 4'd0));

  // R3
  single_byte_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && (pktType == 3'd0 || pktType == 3'd1 || pktType == 3'd3 ||
                  pktType == 3'd4 || pktType == 3'd5))
    |-> (payload == 32'd0 && srcId == 5'd0));

  // R6
  tsctrl_only_ts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktType != 3'd2) |-> tsCtrl == 2'd0);

endmodule

bind instr_trace_parser instr_trace_chk #(.TS_W(TS_W)) chk_i (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .gapTimeout(gapTimeout),
  .pktValid(pktValid), .pktType(pktType), .srcId(srcId), .payload(payload),
  .tsCtrl(tsCtrl), .tsAccum(tsAccum), .excNum(excNum), .excEvent(excEvent)
);

// File: tb/instr_trace_parser_tb.sv
`timescale 1ns/1ps
module instr_trace_parser_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        gapTimeout = 1'b0;
  logic        pktValid;
  logic [2:0]  pktType;
  logic [4:0]  srcId;
  logic [31:0] payload;
  logic [1:0]  tsCtrl;
  logic [31:0] tsAccum;
  logic [8:0]  excNum;
  logic [3:0]  excEvent;

  int checks = 0;
  int errors = 0;
  logic [31:0] expAcc = 32'd0;
  logic [7:0]  pb [0:4];

  always #2.5 clk = ~clk;

  instr_trace_parser dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .gapTimeout(gapTimeout), .pktValid(pktValid), .pktType(pktType),
    .srcId(srcId), .payload(payload), .tsCtrl(tsCtrl), .tsAccum(tsAccum),
    .excNum(excNum), .excEvent(excEvent)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample at the next negedge (output of the edge between)
  task automatic pushByte(input logic [7:0] b, input logic gap);
    byteValid  = 1'b1;
    byteData   = b;
    gapTimeout = gap;
    @(negedge clk);
    byteValid  = 1'b0;
    gapTimeout = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendPkt(input int n, input string tag, input logic [2:0] eType,
                         input logic [4:0] eId, input logic [31:0] ePay,
                         input logic [1:0] eTc, input logic [8:0] eExN,
                         input logic [3:0] eExE);
    for (int i = 0; i < n; i++) begin
      pushByte(pb[i], 1'b0);
      if (i < n - 1) check({tag, " early strobe R11"}, 32'(pktValid), 32'd0);
    end
    check({tag, " valid R11"}, 32'(pktValid), 32'd1);
    check({tag, " type"},     32'(pktType), 32'(eType));
    check({tag, " srcId"},    32'(srcId), 32'(eId));
    check({tag, " payload"},  payload, ePay);
    check({tag, " tsCtrl"},   32'(tsCtrl), 32'(eTc));
    check({tag, " excNum R9"},   32'(excNum), 32'(eExN));
    check({tag, " excEvent R9"}, 32'(excEvent), 32'(eExE));
    check({tag, " tsAccum R7"},  tsAccum, expAcc);
    idle(1);
    check({tag, " one-cycle R11"}, 32'(pktValid), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1
    check("R1 reset pktValid", 32'(pktValid), 32'd0);
    check("R1 reset tsAccum", tsAccum, 32'd0);

    // R3 overflow
    pb[0] = 8'h70;
    sendPkt(1, "R3 overflow", 3'd1, 5'd0, 32'd0, 2'd0, 9'd0, 4'd0);

    // R8 extension / reserved
    pb[0] = 8'h18; sendPkt(1, "R8 swext", 3'd3, 5'd0, 32'd0, 2'd0, 9'd0, 4'd0);
    pb[0] = 8'h2C; sendPkt(1, "R8 hwext", 3'd4, 5'd0, 32'd0, 2'd0, 9'd0, 4'd0);
    pb[0] = 8'h34; sendPkt(1, "R8 reserved", 3'd5, 5'd0, 32'd0, 2'd0, 9'd0, 4'd0);

    // R5 short timestamp 0x50 -> value 5
    pb[0] = 8'h50; expAcc += 32'd5;
    sendPkt(1, "R5 short ts", 3'd2, 5'd0, 32'd5, 2'd0, 9'd0, 4'd0);

    // R6 long timestamp, tc=2, bytes 0x81 0x02 -> 1 + (2<<7)
    pb[0] = 8'hE0; pb[1] = 8'h81; pb[2] = 8'h02; expAcc += 32'd257;
    sendPkt(3, "R6 long ts", 3'd2, 5'd0, 32'd257, 2'd2, 9'd0, 4'd0);

    // R6 forced end at fourth byte (bit 7 still set)
    pb[0] = 8'hF0; pb[1] = 8'hFF; pb[2] = 8'h80; pb[3] = 8'h80; pb[4] = 8'h81;
    v = 32'h7F | (32'h1 << 21); expAcc += v;
    sendPkt(5, "R6 four-byte cap", 3'd2, 5'd0, v, 2'd3, 9'd0, 4'd0);

    // R9 exception enter, number 0x10F: header id1 hw size2 = 0x0E
    pb[0] = 8'h0E; pb[1] = 8'h0F; pb[2] = 8'h11;
    sendPkt(3, "R9 exception", 3'd7, 5'd1, 32'h110F, 2'd0, 9'h10F, 4'd1);

    // R2 sync: 4 zeros + 0x80 ignored, then overflow still decodes
    for (int i = 0; i < 4; i++) pushByte(8'h00, 1'b0);
    pushByte(8'h80, 1'b0);
    check("R2 short zero run no packet", 32'(pktValid), 32'd0);
    pb[0] = 8'h70;
    sendPkt(1, "R2 after ignored 0x80", 3'd1, 5'd0, 32'd0, 2'd0, 9'd0, 4'd0);
    for (int i = 0; i < 5; i++) pushByte(8'h00, 1'b0);
    pb[0] = 8'h80;
    sendPkt(1, "R2 sync five zeros", 3'd0, 5'd0, 32'd0, 2'd0, 9'd0, 4'd0);
    for (int i = 0; i < 7; i++) pushByte(8'h00, 1'b0);
    sendPkt(1, "R2 sync seven zeros", 3'd0, 5'd0, 32'd0, 2'd0, 9'd0, 4'd0);

    // R10 timeout alone drops partial 4-byte packet
    pushByte(8'h0B, 1'b0); pushByte(8'hAA, 1'b0); pushByte(8'hBB, 1'b0);
    gapTimeout = 1'b1; @(negedge clk); gapTimeout = 1'b0;
    check("R10 timeout no packet", 32'(pktValid), 32'd0);
    pb[0] = 8'h70;
    sendPkt(1, "R10 header after timeout", 3'd1, 5'd0, 32'd0, 2'd0, 9'd0, 4'd0);
    // R10 timeout together with a byte: byte is a header
    pushByte(8'h0A, 1'b0); pushByte(8'h11, 1'b0);
    pushByte(8'h70, 1'b1);
    check("R10 concurrent valid", 32'(pktValid), 32'd1);
    check("R10 concurrent type", 32'(pktType), 32'd1);
    idle(1);

    // R4 random source packets
    for (int it = 0; it < 80; it++) begin
      logic [4:0] id; logic hw; logic [1:0] sz; int n; logic [31:0] ep;
      logic [8:0] en; logic [3:0] ee;
      id = 5'($urandom_range(0, 31)); hw = 1'($urandom_range(0, 1));
      if (it < 12) id = 5'd1;
      sz = 2'($urandom_range(1, 3));
      n = (sz == 2'd3) ? 4 : int'(sz);
      pb[0] = {id, hw, sz};
      ep = 32'd0;
      for (int k = 0; k < n; k++) begin
        pb[k+1] = 8'($urandom);
        ep[k*8 +: 8] = pb[k+1];
      end
      en = (hw && id == 5'd1) ? {ep[8], ep[7:0]} : 9'd0;
      ee = (hw && id == 5'd1) ? ep[15:12] : 4'd0;
      sendPkt(n + 1, hw ? "R4 hw source" : "R4 sw source",
              hw ? 3'd7 : 3'd6, id, ep, 2'd0, en, ee);
    end

    // R6/R7 random long and short timestamps
    for (int it = 0; it < 60; it++) begin
      logic [1:0] tc; int nb; logic [31:0] val;
      if (it % 4 == 0) begin
        val = 32'($urandom_range(1, 6));
        pb[0] = {1'b0, val[2:0], 4'h0};
        expAcc += val;
        sendPkt(1, "R5 random short ts", 3'd2, 5'd0, val, 2'd0, 9'd0, 4'd0);
      end else begin
        tc = 2'($urandom_range(0, 3));
        nb = $urandom_range(1, 4);
        pb[0] = {2'b11, tc, 4'h0};
        val = 32'd0;
        for (int k = 0; k < nb; k++) begin
          logic b7;
          b7 = (k < nb - 1) ? 1'b1 : ((k == 3) ? 1'($urandom_range(0, 1)) : 1'b0);
          pb[k+1] = {b7, 7'($urandom)};
          val |= 32'(pb[k+1][6:0]) << (7 * k);
        end
        expAcc += val;
        sendPkt(nb + 1, "R6 random long ts R7", 3'd2, 5'd0, val, tc, 9'd0, 4'd0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule